// File: doc/BRIEF.md
# Accumulator Readout Window with Saturation

This block conditions words read out of a 24-bit accumulator memory into a 9-bit result. The result can feed an external data port or be written into a lookup-table memory. A 4-bit window select picks which nine consecutive bits of the word are kept. A clamp mode forces the result to full scale when the kept bits cannot represent the word. A cumulative mode replaces the raw word with a running total of every word read since the last clear. That total is what a histogram-equalization transfer function needs.

The reader pulses a clear at the start of each readout pass. It then presents one word per valid strobe, with the window, clamp and cumulative controls held at the values chosen for that pass. Each result appears one clock after its strobe, together with a valid flag.

Top module: `acc_window_top`

## Requirements
- R1: While rst_ni is low and after it rises, res_o is 0 and res_valid_o is 0. The running total starts at 0.
- R2: For a window select value s, where bit 0 of win_sel_i is the least significant bit, res_o holds bits s through s+8 of the source word. For example, s=0 takes bits 8..0 and s=15 takes bits 23..15.
- R3: When sat_en_i is 1 and the source word has any 1 in bit positions s+9 through 23, res_o is 511.
- R4: When sat_en_i is 0, or when every bit above the window is 0, res_o is the selected 9-bit window without modification.
- R5: With s=15 the clamp never engages, even when sat_en_i is 1.
- R6: When eq_en_i is 1 on a valid read, the source word is the running total plus the current word. The running total becomes that 24-bit sum, and the sum wraps modulo 2^24.
- R7: A cycle with clr_i high sets the running total to 0. When the same cycle also carries a valid read with eq_en_i at 1, the new total is just that read's word.
- R8: When eq_en_i is 0, the source word is the raw read word and the running total is left unchanged.
- R9: res_valid_o equals rd_valid_i delayed by one clock. res_o changes only in the cycle after a valid read and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Start-of-readout clear of the running total |
| rd_valid_i | input | 1 | Read word strobe |
| rd_data_i | input | 24 | Word read from the accumulator memory |
| win_sel_i | input | 4 | Window start bit s |
| sat_en_i | input | 1 | Clamp enable |
| eq_en_i | input | 1 | Cumulative (running total) enable |
| res_o | output | 9 | Windowed, optionally clamped result |
| res_valid_o | output | 1 | Result valid, one clock after rd_valid_i |

## Verification
The bench targets the window edges. At s=15, a design that wrongly tests bits above 23 would either clamp or pick up garbage. At s=0, a set bit 23 must clamp, and a design with the overflow range off by one would pass the raw bits through instead. It drives a clear on the same cycle as a cumulative read, which catches a design that adds to the stale total. It also drives a total past 2^24, which catches a design that saturates the sum or widens it instead of wrapping. Reads with cumulative mode off sit between cumulative reads, so a design that silently updates the total is caught. Idle cycles confirm that the result holds and that the valid flag drops.

// File: rtl/acw_pkg.sv
package acw_pkg;
  parameter int ACC_W = 24;
  parameter int RES_W = 9;
  localparam int WIN_N = ACC_W - RES_W + 1;
  localparam int SEL_W = $clog2(WIN_N);
  typedef logic [ACC_W-1:0] acc_word_t;
  typedef logic [RES_W-1:0] res_word_t;
endpackage

// File: rtl/acw_window.sv
module acw_window
  import acw_pkg::*;
(
  input  acc_word_t          word_i,
  input  logic [SEL_W-1:0]   sel_i,
  output res_word_t          slice_o,
  output logic               above_o
);
  res_word_t        cand [WIN_N];
  logic [WIN_N-1:0] over;

  for (genvar s = 0; s < WIN_N; s++) begin : g_win
    assign cand[s] = word_i[s +: RES_W];
    if (s + RES_W < ACC_W) begin : g_over
      assign over[s] = |word_i[ACC_W-1:s+RES_W];
    end else begin : g_top
      assign over[s] = 1'b0;
    end
  end

  always_comb begin
    slice_o = cand[0];
    above_o = over[0];
    for (int i = 0; i < WIN_N; i++) begin
      if (sel_i == SEL_W'(i)) begin
        slice_o = cand[i];
        above_o = over[i];
      end
    end
  end

  // R5
  top_window_no_over_chk: assert final (!(sel_i == SEL_W'(WIN_N-1) && above_o));
endmodule

// File: rtl/acw_clamp.sv
module acw_clamp
  import acw_pkg::*;
(
  input  res_word_t slice_i,
  input  logic      above_i,
  input  logic      sat_en_i,
  output res_word_t res_o
);
  always_comb begin
    if (sat_en_i && above_i) res_o = '1;
    else                     res_o = slice_i;
  end
endmodule

// File: rtl/acw_runsum.sv
module acw_runsum
  import acw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      upd_i,
  input  acc_word_t data_i,
  output acc_word_t total_o
);
  acc_word_t sum_q;
  acc_word_t base;

  assign base    = clr_i ? '0 : sum_q;
  assign total_o = base + data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (upd_i) sum_q <= total_o;
    else if (clr_i) sum_q <= '0;
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !$past(upd_i)) |-> sum_q == '0);

  // R8
  hold_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> $stable(sum_q));

  // R6
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i) |=> sum_q == acc_word_t'($past(sum_q) + $past(data_i)));
endmodule

// File: rtl/acc_window_top.sv
module acc_window_top
  import acw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               rd_valid_i,
  input  logic [ACC_W-1:0]   rd_data_i,
  input  logic [SEL_W-1:0]   win_sel_i,
  input  logic               sat_en_i,
  input  logic               eq_en_i,
  output logic [RES_W-1:0]   res_o,
  output logic               res_valid_o
);
  acc_word_t total;
  acc_word_t src;
  res_word_t slice;
  res_word_t res_d;
  logic      above;

  acw_runsum u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .upd_i   (rd_valid_i && eq_en_i),
    .data_i  (rd_data_i),
    .total_o (total)
  );

  assign src = eq_en_i ? total : rd_data_i;

  acw_window u_win (
    .word_i  (src),
    .sel_i   (win_sel_i),
    .slice_o (slice),
    .above_o (above)
  );

  acw_clamp u_clamp (
    .slice_i  (slice),
    .above_i  (above),
    .sat_en_i (sat_en_i),
    .res_o    (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= rd_valid_i;
      if (rd_valid_i) res_o <= res_d;
    end
  end

  // R9
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> res_valid_o == $past(rd_valid_i));

  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> $stable(res_o));

  // R3
  clamp_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && sat_en_i && above) |=> res_o == '1);

  // R4
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !sat_en_i) |=> res_o == $past(slice));
endmodule

// File: tb/tb_acc_window_top.sv
module tb_acc_window_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, vld = 1'b0, sat = 1'b0, eq = 1'b0;
  logic [23:0] data = '0;
  logic [3:0]  sel = '0;
  logic [8:0]  res;
  logic        res_vld;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] m_sum = '0;

  always #2.5 clk = ~clk;

  acc_window_top dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .rd_valid_i(vld),
    .rd_data_i(data), .win_sel_i(sel), .sat_en_i(sat), .eq_en_i(eq),
    .res_o(res), .res_valid_o(res_vld)
  );

  function automatic logic [8:0] ref_res(logic [23:0] w, logic [3:0] s, logic sa);
    logic [23:0] hi;
    hi = w >> (s + 9);
    if (sa && s != 4'd15 && hi != 0) return 9'h1FF;
    return 9'((w >> s) & 24'h1FF);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [23:0] w, logic [3:0] s, logic sa, logic e, logic c);
    logic [23:0] src, base;
    @(negedge clk);
    data = w; sel = s; sat = sa; eq = e; clr = c; vld = 1'b1;
    base = c ? 24'd0 : m_sum;
    src  = e ? base + w : w;
    if (e) m_sum = base + w; else if (c) m_sum = 24'd0;
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    chk({tag, " value"}, 32'(res), 32'(ref_res(src, s, sa)));
    chk("R9 valid", 32'(res_vld), 32'd1);
  endtask

  task automatic idle_chk();
    logic [8:0] prev;
    prev = res;
    data = 24'hFFFFFF; sel = 4'd3; sat = 1'b1;
    @(negedge clk);
    chk("R9 hold", 32'(res), 32'(prev));
    chk("R9 valid low", 32'(res_vld), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 res", 32'(res), 32'd0);
    chk("R1 valid", 32'(res_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res after", 32'(res), 32'd0);

    rd("R2 s0", 24'h0001A5, 4'd0, 1'b0, 1'b0, 1'b0);
    rd("R2 s15", 24'hABCDEF, 4'd15, 1'b0, 1'b0, 1'b0);
    rd("R5 s15 sat", 24'hFFFFFF, 4'd15, 1'b1, 1'b0, 1'b0);
    rd("R3 s0 bit23", 24'h800000, 4'd0, 1'b1, 1'b0, 1'b0);
    rd("R3 s5 bit14", 24'h004000, 4'd5, 1'b1, 1'b0, 1'b0);
    rd("R4 s5 fits", 24'h002FE0, 4'd5, 1'b1, 1'b0, 1'b0);
    rd("R4 sat off", 24'h800123, 4'd0, 1'b0, 1'b0, 1'b0);
    idle_chk();
    rd("R7 clr first", 24'h000010, 4'd0, 1'b0, 1'b1, 1'b1);
    rd("R6 accum", 24'h000020, 4'd0, 1'b0, 1'b1, 1'b0);
    rd("R8 raw", 24'h000005, 4'd0, 1'b0, 1'b0, 1'b0);
    rd("R8 sum kept", 24'h000001, 4'd0, 1'b0, 1'b1, 1'b0);
    rd("R7 clr big", 24'hFFFFFF, 4'd15, 1'b0, 1'b1, 1'b1);
    rd("R6 wrap", 24'h000002, 4'd0, 1'b1, 1'b1, 1'b0);
    idle_chk();

    for (int i = 0; i < 400; i++) begin
      logic [23:0] w;
      w = 24'($urandom) >> ($urandom % 24);
      rd("R2 R3 R4 R6 R8 rand", w, 4'($urandom), 1'($urandom),
         ($urandom % 3) != 0, ($urandom % 16) == 0);
      if (($urandom % 8) == 0) idle_chk();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule